// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every bus cycle and raises a break request when a cycle meets the conditions programmed into one of its two channels. Each channel has a target address with a per-bit ignore mask, an 8-bit address-space identifier (ASID), and a 6-bit condition word. The condition word selects which bus master, which access kind and which direction qualify. The second channel can also compare the cycle's data against a target under its own ignore mask.

When a channel hits, the block sets a sticky flag for that channel and that master. It then pulses a single break request one cycle later, with a code that tells an instruction-fetch break from a data-access break. Software programs the channels, reads the flags and clears them through a small word-indexed register port. Matches that arrive together, or in the cycle just after a request, fold into one request.

Top module: `bus_break_cmp`

## Requirements
- R1: Register indices (4-bit `reg_addr`) are: 0 address A, 1 address mask A, 2 ASID A, 3 condition A, 4 address B, 5 address mask B, 6 ASID B, 7 condition B, 8 data B, 9 data mask B, 10 flags. A write to an index makes that value appear on `reg_rdata` for the same index. Indices 11 to 15 read as zero.
- R2: An address bit whose mask bit is 1 is left out of the compare. Every other bit must equal the channel's address register.
- R3: The ASID register is compared only when `cyc_asid_vld` is 1 and `cyc_dma` is 0. Otherwise the ASID does not affect the match.
- R4: The condition word has three 2-bit groups. Bits [1:0] select the master (01 CPU, 10 DMA, 11 either). Bits [3:2] select the kind (01 instruction fetch, 10 data access, 11 either). Bits [5:4] select the direction (01 read, 10 write, 11 either).
- R5: A channel whose condition word has any group equal to 00 never matches. After reset every condition word is 0.
- R6: Channel B also requires data equality on the bits where data mask B is 0. This applies on data-access cycles only; instruction fetches skip the data compare.
- R7: The flags register holds bit0 = A on a CPU cycle, bit1 = A on a DMA cycle, bit2 = B on a CPU cycle, bit3 = B on a DMA cycle. A hit sets the bit for the channel and the master of that cycle.
- R8: Flags are sticky. Non-matching cycles leave them unchanged. A write to index 10 clears the bits written 0 and leaves the bits written 1 as they were, and can never set a flag. A hit in the same cycle as a clearing write still sets its flag.
- R9: A hit on the clock edge that samples the cycle raises `brk_req` high for exactly one cycle after that edge. While `brk_req` is high, `brk_type` is 01 for an instruction fetch and 10 for a data access; otherwise it is 00.
- R10: Channel hits in the same cycle give one pulse. A hit in the cycle where `brk_req` is already high gives no further pulse, but it still sets its flags.
- R11: Reset clears the address, mask, condition, data and flag registers, and leaves both ASID registers at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_addr | input | 32 | Cycle address |
| cyc_asid | input | 8 | Cycle address-space identifier |
| cyc_asid_vld | input | 1 | `cyc_asid` is meaningful |
| cyc_data | input | 32 | Cycle data |
| cyc_dma | input | 1 | 1 = DMA master, 0 = CPU |
| cyc_data_acc | input | 1 | 1 = data access, 0 = instruction fetch |
| cyc_write | input | 1 | 1 = write, 0 = read |
| brk_req | output | 1 | One-cycle break request |
| brk_type | output | 2 | Break kind code while `brk_req` is high |
| match_flags | output | 4 | Sticky match flags (same as index 10) |

## Verification
On every cycle, the assertions check that a request lasts one cycle and carries a one-hot type code, and that a request always comes with a set flag. They also check that flags only ever rise unless software writes the flag register, and that a channel with a zero group never raises its flags. The address, ASID and data compares under their masks can only be shown by the bench's scenarios. The same holds for the master-dependent choice of flag, the merging of back-to-back and simultaneous hits, the set-wins rule against a clear, and ASID retention across reset.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           cyc_valid,
  input  logic [AW-1:0]  cyc_addr,
  input  logic [IW-1:0]  cyc_asid,
  input  logic           cyc_asid_vld,
  input  logic [DW-1:0]  cyc_data,
  input  logic           cyc_dma,
  input  logic           cyc_data_acc,
  input  logic           cyc_write,
  output logic           brk_req,
  output logic [1:0]     brk_type,
  output logic [3:0]     match_flags
);

  localparam logic [RAW-1:0] IDX_DATA  = RAW'(8);
  localparam logic [RAW-1:0] IDX_DMASK = RAW'(9);
  localparam logic [RAW-1:0] IDX_FLAGS = RAW'(10);

  logic [AW-1:0] tgt_addr [2];
  logic [AW-1:0] tgt_mask [2];
  logic [IW-1:0] tgt_asid [2];
  logic [5:0]    cond     [2];
  logic [DW-1:0] tgt_data, data_mask;
  logic [3:0]    flags;
  logic [1:0]    hit;

  function automatic logic grp_ok(input logic [1:0] g, input logic second);
    return second ? g[1] : g[0];
  endfunction

  wire flag_wr = reg_wr && reg_addr == IDX_FLAGS;
  wire fire    = (|hit) && !brk_req;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire sel = reg_wr && reg_addr[RAW-1:2] == (RAW-2)'(c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_addr[c] <= '0;
        tgt_mask[c] <= '0;
        cond[c]     <= '0;
      end else if (sel) begin
        case (reg_addr[1:0])
          2'd0:    tgt_addr[c] <= reg_wdata[AW-1:0];
          2'd1:    tgt_mask[c] <= reg_wdata[AW-1:0];
          2'd3:    cond[c]     <= reg_wdata[5:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk)
      if (sel && reg_addr[1:0] == 2'd2) tgt_asid[c] <= reg_wdata[IW-1:0];

    wire bus_ok  = grp_ok(cond[c][1:0], cyc_dma) && grp_ok(cond[c][3:2], cyc_data_acc)
                   && grp_ok(cond[c][5:4], cyc_write);
    wire addr_ok = ((cyc_addr ^ tgt_addr[c]) & ~tgt_mask[c]) == '0;
    wire asid_ok = cyc_dma || !cyc_asid_vld || cyc_asid == tgt_asid[c];
    wire data_ok = (c == 0) || !cyc_data_acc || ((cyc_data ^ tgt_data) & ~data_mask) == '0;

    assign hit[c] = cyc_valid && bus_ok && addr_ok && asid_ok && data_ok;

    // R5
    chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[c][1:0] == 2'b00 || cond[c][3:2] == 2'b00 || cond[c][5:4] == 2'b00)
      |=> (flags[2*c+:2] & ~$past(flags[2*c+:2])) == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_data  <= '0;
      data_mask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == IDX_DATA)  tgt_data  <= reg_wdata[DW-1:0];
      if (reg_addr == IDX_DMASK) data_mask <= reg_wdata[DW-1:0];
    end
  end

  wire [3:0] flag_set = {hit[1] & cyc_dma, hit[1] & ~cyc_dma, hit[0] & cyc_dma, hit[0] & ~cyc_dma};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      brk_req  <= 1'b0;
      brk_type <= 2'b00;
    end else begin
      flags    <= (flag_wr ? (flags & reg_wdata[3:0]) : flags) | flag_set;
      brk_req  <= fire;
      brk_type <= fire ? (cyc_data_acc ? 2'b10 : 2'b01) : 2'b00;
    end
  end

  assign match_flags = flags;

  always_comb begin
    case (reg_addr)
      RAW'(0):   reg_rdata = 32'(tgt_addr[0]);
      RAW'(1):   reg_rdata = 32'(tgt_mask[0]);
      RAW'(2):   reg_rdata = 32'(tgt_asid[0]);
      RAW'(3):   reg_rdata = 32'(cond[0]);
      RAW'(4):   reg_rdata = 32'(tgt_addr[1]);
      RAW'(5):   reg_rdata = 32'(tgt_mask[1]);
      RAW'(6):   reg_rdata = 32'(tgt_asid[1]);
      RAW'(7):   reg_rdata = 32'(cond[1]);
      IDX_DATA:  reg_rdata = 32'(tgt_data);
      IDX_DMASK: reg_rdata = 32'(data_mask);
      IDX_FLAGS: reg_rdata = 32'(flags);
      default:   reg_rdata = '0;
    endcase
  end

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  // R9
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req ? $countones(brk_type) == 1 : brk_type == 2'b00);

  // R7
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> flags != 4'b0000);

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (flags & $past(flags)) == $past(flags));

endmodule

// File: tb/bus_break_cmp_test.sv
`timescale 1ns/1ps
module bus_break_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [7:0]  cyc_asid = '0;
  logic        cyc_asid_vld = 1'b0;
  logic [31:0] cyc_data = '0;
  logic        cyc_dma = 1'b0, cyc_data_acc = 1'b0, cyc_write = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_type;
  logic [3:0]  match_flags;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bus_break_cmp uut (.*);

  // {addr, asid, asid_vld, data, dma, data_acc, write, exp_req, exp_type, exp_flags}
  localparam int NV = 14;
  localparam logic [82:0] VEC [NV] = '{
    {32'h1000_0055, 8'h12, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0001},
    {32'h1000_0055, 8'h99, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0010},
    {32'h1000_0155, 8'h12, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'b0000},
    {32'h1000_0055, 8'h13, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'b0000},
    {32'h1000_00AA, 8'h77, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0001},
    {32'h1000_0055, 8'h12, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'b0000},
    {32'h1000_0055, 8'h12, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0000},
    {32'h2000_004C, 8'h34, 1'b1, 32'h5555_55AB, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 4'b0100},
    {32'h2000_004C, 8'h34, 1'b1, 32'h5555_55AC, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000},
    {32'h2000_004C, 8'h34, 1'b1, 32'h5555_55AB, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000},
    {32'h2000_004C, 8'h34, 1'b1, 32'h5555_55AB, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0000},
    {32'h2000_0080, 8'h34, 1'b1, 32'h5555_55AB, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000},
    {32'h2000_0043, 8'h35, 1'b1, 32'h5555_55AB, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000},
    {32'h2000_004F, 8'h35, 1'b0, 32'h1234_56AB, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 4'b0100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [82:0] v);
    cyc_addr = v[82:51]; cyc_asid = v[50:43]; cyc_asid_vld = v[42];
    cyc_data = v[41:10]; cyc_dma = v[9]; cyc_data_acc = v[8]; cyc_write = v[7];
    cyc_valid = 1'b1;
  endtask

  task automatic program_chans();
    wr(0, 32'h1000_0000); wr(1, 32'h0000_00FF); wr(2, 32'h12); wr(3, 32'h17);
    wr(4, 32'h2000_0040); wr(5, 32'h0000_000F); wr(6, 32'h34); wr(7, 32'h29);
    wr(8, 32'h0000_00AB); wr(9, 32'hFFFF_FF00);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int pulses;
    do_reset();
    #1;
    chk("R9 reset req", 32'(brk_req), 0);
    chk("R9 reset type", 32'(brk_type), 0);
    chk("R7 reset flags", 32'(match_flags), 0);
    rd(3, r); chk("R5 reset cond A", r, 0);
    rd(7, r); chk("R5 reset cond B", r, 0);
    rd(0, r); chk("R11 reset addr A", r, 0);

    // R11: ASID kept across reset; R5: disabled after reset
    wr(2, 32'h5A); wr(0, 32'h1000_0000); wr(1, 32'hFF);
    do_reset();
    rd(2, r); chk("R11 asid kept", r, 32'h5A);
    rd(0, r); chk("R11 addr cleared", r, 0);
    @(negedge clk); drive(VEC[4]);
    @(negedge clk); #1;
    chk("R5 no req after reset", 32'(brk_req), 0);
    chk("R5 no flag after reset", 32'(match_flags), 0);
    cyc_valid = 1'b0;

    // R1 readback
    program_chans();
    rd(4, r); chk("R1 addr B", r, 32'h2000_0040);
    rd(9, r); chk("R1 dmask B", r, 32'hFFFF_FF00);
    rd(6, r); chk("R1 asid B", r, 32'h34);
    rd(7, r); chk("R1 cond B", r, 32'h29);
    rd(4'd12, r); chk("R1 unmapped", r, 0);

    // table walk: R2 R3 R4 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      wr(10, 32'h0);
      drive(VEC[i]);
      @(negedge clk); #1;
      chk($sformatf("R2/R3/R4/R6 vec%0d req", i), 32'(brk_req), 32'(VEC[i][6]));
      chk($sformatf("R9 vec%0d type", i), 32'(brk_type), 32'(VEC[i][5:4]));
      chk($sformatf("R7 vec%0d flags", i), 32'(match_flags), 32'(VEC[i][3:0]));
      cyc_valid = 1'b0;
      @(negedge clk); #1;
      chk($sformatf("R9 vec%0d pulse ends", i), 32'(brk_req), 0);
    end

    // R8 sticky
    wr(10, 32'h0);
    @(negedge clk); drive(VEC[0]);
    @(negedge clk); drive(VEC[2]);
    @(negedge clk); drive(VEC[8]);
    @(negedge clk); cyc_valid = 1'b0; #1;
    chk("R8 sticky after misses", 32'(match_flags), 32'h1);
    wr(10, 32'hF); #1;
    chk("R8 write ones no effect", 32'(match_flags), 32'h1);
    rd(10, r); chk("R8 flags readback", r, 32'h1);
    wr(10, 32'hE); #1;
    chk("R8 write zero clears", 32'(match_flags), 32'h0);

    // R8 set wins over clear
    @(negedge clk); drive(VEC[7]); reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 32'h0;
    @(negedge clk); reg_wr = 1'b0; cyc_valid = 1'b0; #1;
    chk("R8 set wins", 32'(match_flags), 32'h4);

    // R10 back-to-back: data break then instruction break
    wr(10, 32'h0);
    pulses = 0;
    @(negedge clk); drive(VEC[7]);
    @(negedge clk); #1; pulses += int'(brk_req); drive(VEC[0]);
    @(negedge clk); #1; pulses += int'(brk_req); cyc_valid = 1'b0;
    @(negedge clk); #1; pulses += int'(brk_req);
    chk("R10 back-to-back one pulse", 32'(pulses), 1);
    chk("R10 back-to-back both flags", 32'(match_flags), 32'h5);

    // R10 same cycle, both channels
    wr(0, 32'h2000_0000); wr(3, 32'h3F); wr(10, 32'h0);
    pulses = 0;
    @(negedge clk); drive(VEC[13]);
    @(negedge clk); #1; pulses += int'(brk_req);
    chk("R10 simultaneous type", 32'(brk_type), 32'h2);
    cyc_valid = 1'b0;
    @(negedge clk); #1; pulses += int'(brk_req);
    chk("R10 simultaneous one pulse", 32'(pulses), 1);
    chk("R10 simultaneous flags", 32'(match_flags), 32'h5);

    // R5 one group at 00
    wr(3, 32'h0F); wr(10, 32'h0);
    @(negedge clk); drive(VEC[13]); cyc_data_acc = 1'b1; cyc_addr = 32'h2000_0010;
    @(negedge clk); #1;
    chk("R5 zero group req", 32'(brk_req), 0);
    chk("R5 zero group flags", 32'(match_flags), 0);
    cyc_valid = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule